// File: doc/BRIEF.md
# Masked GPIO Port with Level Alarms

A single general-purpose I/O port holds three registers: the output value, the input value as seen by the logic, and the output enable. Software does not write these registers directly. It issues atomic commands that set or clear output bits and that turn pins into inputs or into outputs. Two fixed masks, given as parameters, decide which bits may change value and which may change direction. Every update is filtered through these masks, so bits outside a mask stay at their reset value.

The port also holds a high-alarm mask and a low-alarm mask. A combinational ready flag is raised while any pin watched by the high mask reads 1, or while any pin watched by the low mask reads 0. The input pins pass through a two-flop synchroniser and then into the sampled input register. The width is a parameter; typical values are 8 and 18.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, dout, oe, din, both alarm masks and rsp_valid are 0, and ready is 0.
- R2: Command bit 0 (set-bits) ORs (cmd_arg AND CHG_BITS) into dout, visible after the next rising edge. The default CHG_BITS is 0x3C0FF.
- R3: Command bit 1 (clear-bits) clears in dout exactly the bits of (cmd_arg AND CHG_BITS).
- R4: Command bit 2 (set-input) clears the oe bits of (cmd_arg AND CHG_DIR). One cycle later rsp_valid is 1 and rsp_data is the inverted new oe, where 1 means input. The default CHG_DIR is 0x0FF0F.
- R5: Command bit 3 (set-output) ORs (cmd_arg AND CHG_DIR) into oe, where 1 means output. One cycle later rsp_valid is 1 and rsp_data is the new oe.
- R6: din equals pin_in as it stood three rising edges earlier. Two edges after a change, din still holds the old value.
- R7: Command bit 4 ORs cmd_arg into the high-alarm mask, and command bit 5 ORs it into the low-alarm mask. ready is 1 exactly when (din AND high) or (NOT din AND low) is nonzero.
- R8: Command bit 6 removes the bits of cmd_arg from both alarm masks.
- R9: When several command bits are set in one cycle, only the lowest-numbered one takes effect. The others have no effect.
- R10: Bits of dout outside CHG_BITS and bits of oe outside CHG_DIR never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 7 | Command strobes; bit n is command code n |
| cmd_arg | input | WIDTH | Bit argument of the command |
| pin_in | input | WIDTH | Raw input pins |
| dout | output | WIDTH | Output data register |
| oe | output | WIDTH | Output enable (1 = output) |
| din | output | WIDTH | Synchronised input data |
| ready | output | 1 | Alarm level match |
| rsp_valid | output | 1 | Direction command response valid |
| rsp_data | output | WIDTH | Direction command response |

## Verification
Two commands can be raised in the same cycle. The bench strobes set-bits together with clear-bits, set-input together with set-output, and add-high-alarm together with clear-alarm. In each case it judges the result on dout, oe, ready and the response queue, expecting only the lower code to take effect. Alarm matching is also run against pin changes, so that the three-edge input latency shows up in when ready moves.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int WIDTH = 18,
  parameter logic [WIDTH-1:0] CHG_BITS = 18'h3C0FF,
  parameter logic [WIDTH-1:0] CHG_DIR  = 18'h0FF0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [6:0]       cmd_req,
  input  logic [WIDTH-1:0] cmd_arg,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] din,
  output logic             ready,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data
);
  logic [6:0]       win;
  logic [WIDTH-1:0] bsel, dsel, sync1, sync2, hi_mask, lo_mask;

  assign win   = cmd_req & (~cmd_req + 7'd1);
  assign bsel  = cmd_arg & CHG_BITS;
  assign dsel  = cmd_arg & CHG_DIR;
  assign ready = |(din & hi_mask) | |(~din & lo_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; din <= '0;
      dout <= '0; oe <= '0; hi_mask <= '0; lo_mask <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      din   <= sync2;
      rsp_valid <= win[2] | win[3];
      if (win[0]) dout <= dout | bsel;
      if (win[1]) dout <= dout & ~bsel;
      if (win[2]) begin
        oe       <= oe & ~dsel;
        rsp_data <= ~(oe & ~dsel);
      end
      if (win[3]) begin
        oe       <= oe | dsel;
        rsp_data <= oe | dsel;
      end
      if (win[4]) hi_mask <= hi_mask | cmd_arg;
      if (win[5]) lo_mask <= lo_mask | cmd_arg;
      if (win[6]) begin
        hi_mask <= hi_mask & ~cmd_arg;
        lo_mask <= lo_mask & ~cmd_arg;
      end
    end
  end

  AST_FIXED_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dout & ~CHG_BITS)); // R10
  AST_FIXED_OE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(oe & ~CHG_DIR)); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req[0] && cmd_req[1]) |=> ((dout & $past(bsel)) == $past(bsel))); // R9
  AST_OUT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req[3] && cmd_req[2:0] == 3'b0) |=> (rsp_valid && rsp_data == oe)); // R5
  AST_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req[2] && cmd_req[1:0] == 2'b0) |=> (rsp_valid && rsp_data == ~oe)); // R4
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req[6] && cmd_req[5:0] == 6'b0 && &cmd_arg) |=> !ready); // R8
endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  localparam int W = 18;
  localparam logic [W-1:0] CB = 18'h3C0FF;
  localparam logic [W-1:0] CD = 18'h0FF0F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] cmd_req = '0;
  logic [W-1:0] cmd_arg = '0, pin_in = '0;
  logic [W-1:0] dout, oe, din, rsp_data;
  logic ready, rsp_valid;
  int tests = 0, fails = 0;
  logic [W-1:0] m_dout = '0, m_oe = '0, m_hi = '0, m_lo = '0, m_din = '0;
  logic [W-1:0] expq[$];

  gpio_mask_port #(.WIDTH(W), .CHG_BITS(CB), .CHG_DIR(CD)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_arg(cmd_arg),
    .pin_in(pin_in), .dout(dout), .oe(oe), .din(din), .ready(ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (expq.size() == 0) chk("R4/R5 unexpected response", rsp_data, '0 ^ 18'h3FFFF ^ rsp_data ^ 18'h1);
    else chk("R4/R5 response", rsp_data, expq.pop_front());
  end

  function automatic logic m_ready();
    return |(m_din & m_hi) | |(~m_din & m_lo);
  endfunction

  task automatic issue(input string tag, input logic [6:0] req, input logic [W-1:0] arg);
    int k;
    cmd_req = req; cmd_arg = arg;
    k = -1;
    for (int i = 6; i >= 0; i--) if (req[i]) k = i;
    case (k)
      0: m_dout = m_dout | (arg & CB);
      1: m_dout = m_dout & ~(arg & CB);
      2: begin m_oe = m_oe & ~(arg & CD); expq.push_back(~m_oe); end
      3: begin m_oe = m_oe | (arg & CD); expq.push_back(m_oe); end
      4: m_hi = m_hi | arg;
      5: m_lo = m_lo | arg;
      6: begin m_hi = m_hi & ~arg; m_lo = m_lo & ~arg; end
      default: ;
    endcase
    @(negedge clk);
    cmd_req = '0; cmd_arg = '0;
    chk({tag, " dout"}, dout, m_dout);
    chk({tag, " oe"}, oe, m_oe);
    chk({tag, " ready"}, {17'b0, ready}, {17'b0, m_ready()});
  endtask

  task automatic set_pins(input string tag, input logic [W-1:0] v);
    pin_in = v;
    repeat (2) @(negedge clk);
    chk({tag, " R6 din old after two edges"}, din, m_din);
    @(negedge clk);
    m_din = v;
    chk({tag, " R6 din after three edges"}, din, v);
    chk({tag, " R7 ready"}, {17'b0, ready}, {17'b0, m_ready()});
  endtask

  initial begin
    #(200000 * 20);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 dout", dout, '0);
    chk("R1 oe", oe, '0);
    chk("R1 din", din, '0);
    chk("R1 ready", {17'b0, ready}, 18'h0);
    chk("R1 rsp_valid", {17'b0, rsp_valid}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    issue("R2 set all / R10", 7'b0000001, 18'h3FFFF);
    chk("R10 fixed dout bits", dout & ~CB, '0);
    issue("R3 clear", 7'b0000010, 18'h000F0);
    issue("R5 set-output all / R10", 7'b0001000, 18'h3FFFF);
    chk("R10 fixed oe bits", oe & ~CD, '0);
    issue("R4 set-input", 7'b0000100, 18'h00003);
    issue("R4 set-input masked bits", 7'b0000100, 18'h30030);
    issue("R3 clear masked bits", 7'b0000010, 18'h03F00);
    issue("R9 set beats clear", 7'b0000011, 18'h000F3);
    issue("R9 input beats output", 7'b0001100, 18'h00F00);
    issue("R7 low alarm", 7'b0100000, 18'h00001);
    issue("R8 clear alarm", 7'b1000000, 18'h00001);
    issue("R7 high alarm", 7'b0010000, 18'h00010);
    set_pins("R7 high pin", 18'h00010);
    set_pins("R7 pin drop", 18'h20000);
    issue("R9 add-high beats clear", 7'b1010000, 18'h20000);
    issue("R8 clear all alarms", 7'b1000000, 18'h3FFFF);
    issue("R5 set-output again", 7'b0001000, 18'h00F00);
    @(negedge clk);
    chk("R4/R5 queue drained", expq.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule